// File: doc/BRIEF.md
# Triplicated-Function Capture and Mismatch Checker

This block guards a group of triplicated functions. Each function has three redundant copies, and each copy drives one word. A word-wise majority voter per function merges the three words into one voted word. The voter also raises a disagreement flag whenever the three words are not all identical. The voted words and flags leave the block at once, so a single bad copy is masked with no added latency.

A capture strobe snapshots every copy's word, every voted word and every disagreement flag into one long parallel-load shift register. The snapshot is then streamed out one bit per enabled cycle. A stream judge reads the returning serial stream and decides, for each function, whether it is healthy, which copy disagrees, whether the voter itself is inconsistent, or whether the pattern points at a broken capture path rather than at the copies.

The serial stream leaves the block on `scan_out` and comes back on `stream_in`. In normal use the two are tied together outside the block. Any path the integrator inserts between them, such as a wider chain or an off-block consumer, is then judged exactly as it arrives.

Top module: `tmr_capture_checker`

## Requirements
- R1: For every function, `voted` equals the bitwise majority of that function's three copy words, in the same cycle and with no register stage. When two copies agree, this is their common word.
- R2: `vote_err[f]` is 1 exactly when the three copy words of function f are not all equal, in the same cycle.
- R3: A cycle with `capture` high loads the snapshot in that one cycle. From the next cycle on, `scan_out` presents the chain's first bit. Chain order: function 0 first, then increasing index. Within a function the order is copy A word, copy B word, copy C word, voted word (each MSB first), then the disagreement flag. Each function therefore takes 4*W+1 bits.
- R4: While a snapshot is pending and `shift_en` is high (with `capture` low), the chain advances one bit per cycle. With `shift_en` low, `scan_out` holds.
- R5: `scan_done` is a one-cycle pulse in the cycle after the edge that shifts the last chain bit. Further `shift_en` cycles before the next capture produce no pulse, and `scan_out` reads 0.
- R6: `result_valid` rises in the same cycle as `scan_done` and stays high until the next capture, which clears it on the following cycle. Reset clears it and all codes. The 3-bit code of function f sits at `result_code[3f+2:3f]`.
- R7: The code is 0 (healthy) when the three returned copy words, the returned voted word and the returned flag are mutually consistent and all copies agree.
- R8: The code is 1, 2 or 3 when exactly copy A, B or C respectively differs from the other two, and the returned voted word and flag are consistent with that.
- R9: The code is 4 (voter suspect) when at least two copies agree but the returned voted word differs from their word, or the returned flag does not match whether the copies all agree.
- R10: The code is 5 (capture path suspect) when all three returned copy words differ pairwise. This check takes priority over codes 1 to 4.
- R11: A capture while a stream is in progress restarts the stream from the first bit of a fresh snapshot. The results are cleared, and `scan_done` follows exactly LEN shift cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_a | input | NUM_FN*W | Copy A words, function f at bits [fW+W-1:fW] |
| mod_b | input | NUM_FN*W | Copy B words |
| mod_c | input | NUM_FN*W | Copy C words |
| capture | input | 1 | Snapshot strobe |
| shift_en | input | 1 | Advance the chain one bit |
| stream_in | input | 1 | Returned serial stream read by the judge |
| voted | output | NUM_FN*W | Majority words |
| vote_err | output | NUM_FN | Per-function disagreement flags |
| scan_out | output | 1 | Serial chain output |
| scan_done | output | 1 | Pulse after the last chain bit |
| result_valid | output | 1 | Codes are complete |
| result_code | output | NUM_FN*3 | Per-function verdict codes |

## Verification
Any wrong internal state appears at the ports quickly. A wrongly loaded or mis-ordered snapshot bit shows on `scan_out` in the very cycle it is due. A miscounted chain shows as `scan_done` early or late by at least one cycle. A segment-position error in the judge shows as a wrong code the moment `result_valid` rises. The voter is purely combinational, so a fault there is visible on `voted` or `vote_err` in the same cycle the inputs change. The bench therefore compares every output on every clock against a behavioural model, injecting bit flips on the return path to reach the voter-suspect and capture-path verdicts.

// File: rtl/tmr_chk_pkg.sv
package tmr_chk_pkg;
   typedef enum logic [2:0] {
      FC_OK    = 3'd0,
      FC_MOD_A = 3'd1,
      FC_MOD_B = 3'd2,
      FC_MOD_C = 3'd3,
      FC_VOTER = 3'd4,
      FC_CHAIN = 3'd5
   } fault_code_e;
endpackage

// File: rtl/tmr_word_voter.sv
module tmr_word_voter #(
   parameter int W = 8
) (
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   input  logic [W-1:0] in_c,
   output logic [W-1:0] word,
   output logic         disagree
);
   // purely combinational: majority and word-level disagreement
   always_comb begin
      word     = (in_a & in_b) | (in_b & in_c) | (in_a & in_c);
      disagree = (in_a != in_b) || (in_b != in_c);
   end
endmodule

// File: rtl/tmr_snap_chain.sv
module tmr_snap_chain #(
   parameter int LEN = 34
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           shift_en,
   input  logic [LEN-1:0] par_in,
   output logic           sdo,
   output logic           shift_fire,
   output logic           done
);
   localparam int CW = $clog2(LEN + 1);

   logic [LEN-1:0] sr;
   logic           active;
   logic [CW-1:0]  cnt;

   assign shift_fire = shift_en & active & ~load;
   assign sdo        = sr[LEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr     <= '0;
         active <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            sr     <= par_in;
            active <= 1'b1;
            cnt    <= '0;
         end else if (shift_fire) begin
            sr  <= {sr[LEN-2:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LEN - 1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_stream_judge.sv
module tmr_stream_judge
   import tmr_chk_pkg::*;
#(
   parameter int NUM_FN = 2,
   parameter int W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                take,
   input  logic                sdi,
   output logic [NUM_FN*3-1:0] codes,
   output logic                valid
);
   localparam int SEG = 4 * W + 1;
   localparam int PW  = $clog2(SEG);
   localparam int FW  = (NUM_FN > 1) ? $clog2(NUM_FN) : 1;
   localparam int OFA = SEG - 1;
   localparam int OFB = SEG - 1 - W;
   localparam int OFC = SEG - 1 - 2 * W;
   localparam int OFV = SEG - 1 - 3 * W;

   logic [SEG-2:0] acc;
   logic [SEG-1:0] seg_now;
   logic [PW-1:0]  pos;
   logic [FW-1:0]  fn;
   logic [W-1:0]   wa, wb, wc, wv, maj;
   logic           eq_ab, eq_bc, eq_ac, flag, flag_exp;
   fault_code_e    verdict;

   assign seg_now = {acc, sdi};

   always_comb begin
      wa       = seg_now[OFA -: W];
      wb       = seg_now[OFB -: W];
      wc       = seg_now[OFC -: W];
      wv       = seg_now[OFV -: W];
      flag     = seg_now[0];
      eq_ab    = (wa == wb);
      eq_bc    = (wb == wc);
      eq_ac    = (wa == wc);
      maj      = (eq_ab || eq_ac) ? wa : wb;
      flag_exp = !(eq_ab && eq_bc);
      if (!eq_ab && !eq_bc && !eq_ac)        verdict = FC_CHAIN;
      else if (wv != maj || flag != flag_exp) verdict = FC_VOTER;
      else if (wa != maj)                     verdict = FC_MOD_A;
      else if (wb != maj)                     verdict = FC_MOD_B;
      else if (wc != maj)                     verdict = FC_MOD_C;
      else                                    verdict = FC_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc   <= '0;
         pos   <= '0;
         fn    <= '0;
         codes <= '0;
         valid <= 1'b0;
      end else if (take) begin
         acc <= seg_now[SEG-2:0];
         if (pos == PW'(SEG - 1)) begin
            pos                        <= '0;
            codes[int'(fn) * 3 +: 3]   <= verdict;
            fn                         <= fn + 1'b1;
            if (fn == FW'(NUM_FN - 1)) valid <= 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_capture_checker.sv
module tmr_capture_checker #(
   parameter int NUM_FN = 2,
   parameter int W      = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FN*W-1:0] mod_a,
   input  logic [NUM_FN*W-1:0] mod_b,
   input  logic [NUM_FN*W-1:0] mod_c,
   input  logic                capture,
   input  logic                shift_en,
   input  logic                stream_in,
   output logic [NUM_FN*W-1:0] voted,
   output logic [NUM_FN-1:0]   vote_err,
   output logic                scan_out,
   output logic                scan_done,
   output logic                result_valid,
   output logic [NUM_FN*3-1:0] result_code
);
   localparam int SEG = 4 * W + 1;
   localparam int LEN = NUM_FN * SEG;

   if (NUM_FN < 1) begin : g_bad_fn
      $error("NUM_FN must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("W must be at least 1");
   end

   logic [LEN-1:0] snap;
   logic           fire;

   for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
      tmr_word_voter #(.W(W)) u_vote (
         .in_a     (mod_a[f*W +: W]),
         .in_b     (mod_b[f*W +: W]),
         .in_c     (mod_c[f*W +: W]),
         .word     (voted[f*W +: W]),
         .disagree (vote_err[f])
      );
      assign snap[LEN-1-f*SEG -: SEG] =
         {mod_a[f*W +: W], mod_b[f*W +: W], mod_c[f*W +: W],
          voted[f*W +: W], vote_err[f]};
   end

   tmr_snap_chain #(.LEN(LEN)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (capture),
      .shift_en   (shift_en),
      .par_in     (snap),
      .sdo        (scan_out),
      .shift_fire (fire),
      .done       (scan_done)
   );

   tmr_stream_judge #(.NUM_FN(NUM_FN), .W(W)) u_judge (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (capture),
      .take    (fire),
      .sdi     (stream_in),
      .codes   (result_code),
      .valid   (result_valid)
   );
endmodule

// File: rtl/tmr_capture_checker_sva.sv
module tmr_capture_checker_sva #(
   parameter int NUM_FN = 2,
   parameter int W      = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_FN*W-1:0] mod_a,
   input logic [NUM_FN*W-1:0] mod_b,
   input logic [NUM_FN*W-1:0] mod_c,
   input logic                capture,
   input logic                shift_en,
   input logic [NUM_FN*W-1:0] voted,
   input logic [NUM_FN-1:0]   vote_err,
   input logic                scan_out,
   input logic                scan_done,
   input logic                result_valid,
   input logic [NUM_FN*3-1:0] result_code
);
   for (genvar f = 0; f < NUM_FN; f++) begin : g_chk
      // R1: two agreeing copies win
      a_r1_pair_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_b[f*W +: W] == mod_c[f*W +: W]) |-> (voted[f*W +: W] == mod_b[f*W +: W]));
      // R2: flag clear when all agree, set otherwise
      a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_a[f*W +: W] == mod_b[f*W +: W] && mod_a[f*W +: W] == mod_c[f*W +: W]) |-> !vote_err[f]);
      a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_a[f*W +: W] != mod_c[f*W +: W]) |-> vote_err[f]);
      // R7..R10: only defined codes while valid
      a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
         result_valid |-> (result_code[f*3 +: 3] <= 3'd5));
   end

   // R4: chain holds when not shifting
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !capture) |=> $stable(scan_out));
   // R5: done is one cycle wide and follows a shift
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);
   a_r5_done_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> ($past(shift_en) && !$past(capture)));
   // R6: valid rises with done, cleared by capture
   a_r6_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(result_valid) |-> scan_done);
   a_r6_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !result_valid);
endmodule

bind tmr_capture_checker tmr_capture_checker_sva #(.NUM_FN(NUM_FN), .W(W)) u_sva (
   .clk(clk), .rst_n(rst_n), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
   .capture(capture), .shift_en(shift_en), .voted(voted), .vote_err(vote_err),
   .scan_out(scan_out), .scan_done(scan_done), .result_valid(result_valid),
   .result_code(result_code)
);

// File: tb/tmr_capture_checker_test.sv
`timescale 1ns/1ps
module tmr_capture_checker_test;
   localparam int NF  = 2;
   localparam int W   = 4;
   localparam int SEG = 4 * W + 1;
   localparam int LEN = NF * SEG;

   logic clk = 0, rst_n = 0, capture = 0, shift_en = 0, inj_bit = 0;
   logic [NF*W-1:0] mod_a = 0, mod_b = 0, mod_c = 0, voted;
   logic [NF-1:0] vote_err;
   logic scan_out, scan_done, result_valid, stream_in;
   logic [NF*3-1:0] result_code;
   logic [LEN-1:0] inj = 0;

   int total = 0, bad = 0;
   bit finished = 0;

   // model state
   int q[$], col[$];
   int m_pos = 0, m_codes[NF];
   bit m_act = 0, m_done = 0, m_valid = 0;

   always #4 clk = ~clk;
   assign stream_in = scan_out ^ inj_bit;

   tmr_capture_checker #(.NUM_FN(NF), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
      .capture(capture), .shift_en(shift_en), .stream_in(stream_in),
      .voted(voted), .vote_err(vote_err), .scan_out(scan_out),
      .scan_done(scan_done), .result_valid(result_valid), .result_code(result_code));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int bmaj(int a, int b, int c);
      int r = 0;
      for (int i = 0; i < W; i++)
         if (a[i] + b[i] + c[i] >= 2) r |= (1 << i);
      return r;
   endfunction

   function automatic string code_req(int c);
      if (c == 0) return "R7";
      if (c <= 3) return "R8";
      if (c == 4) return "R9";
      return "R10";
   endfunction

   function automatic int word_at(int base);
      int r = 0;
      for (int i = 0; i < W; i++) r = (r << 1) | col[base + i];
      return r;
   endfunction

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); col.delete();
         m_pos = 0; m_act = 0; m_done = 0; m_valid = 0;
         foreach (m_codes[f]) m_codes[f] = 0;
      end else begin
         m_done = 0;
         if (capture) begin
            q.delete(); col.delete();
            for (int f = 0; f < NF; f++) begin
               int a, b, c, w[4];
               a = mod_a[f*W +: W]; b = mod_b[f*W +: W]; c = mod_c[f*W +: W];
               w[0] = a; w[1] = b; w[2] = c; w[3] = bmaj(a, b, c);
               for (int k = 0; k < 4; k++)
                  for (int i = W - 1; i >= 0; i--) q.push_back(w[k][i]);
               q.push_back((a == b && b == c) ? 0 : 1);
            end
            m_pos = 0; m_act = 1; m_valid = 0;
            foreach (m_codes[f]) m_codes[f] = 0;
         end else if (shift_en && m_act) begin
            col.push_back(q.pop_front() ^ int'(inj[m_pos]));
            m_pos++;
            if (m_pos == LEN) begin
               m_act = 0; m_done = 1; m_valid = 1;
               for (int f = 0; f < NF; f++) begin
                  int a, b, c, v, e, mj, ee;
                  a = word_at(f*SEG); b = word_at(f*SEG + W);
                  c = word_at(f*SEG + 2*W); v = word_at(f*SEG + 3*W);
                  e = col[f*SEG + 4*W];
                  mj = (a == b || a == c) ? a : b;
                  ee = (a == b && b == c) ? 0 : 1;
                  if (a != b && b != c && a != c) m_codes[f] = 5;
                  else if (v != mj || e != ee)    m_codes[f] = 4;
                  else if (a != mj)               m_codes[f] = 1;
                  else if (b != mj)               m_codes[f] = 2;
                  else if (c != mj)               m_codes[f] = 3;
                  else                            m_codes[f] = 0;
               end
            end
         end
      end
   end

   // compare on every falling edge; also set the injected return bit
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int f = 0; f < NF; f++) begin
            int a, b, c;
            a = mod_a[f*W +: W]; b = mod_b[f*W +: W]; c = mod_c[f*W +: W];
            chk(voted[f*W +: W] == W'(bmaj(a, b, c)), "R1", voted[f*W +: W], bmaj(a, b, c));
            chk(vote_err[f] == !(a == b && b == c), "R2", vote_err[f], !(a == b && b == c));
         end
         chk(scan_out == ((q.size() > 0) ? q[0][0] : 1'b0), (m_pos > 0) ? "R4" : "R3",
             scan_out, (q.size() > 0) ? q[0] : 0);
         chk(scan_done == m_done, "R5", scan_done, m_done);
         chk(result_valid == m_valid, "R6", result_valid, m_valid);
         if (m_valid)
            for (int f = 0; f < NF; f++)
               chk(result_code[f*3 +: 3] == 3'(m_codes[f]), code_req(m_codes[f]),
                   result_code[f*3 +: 3], m_codes[f]);
      end
      inj_bit = (m_pos < LEN) ? inj[m_pos] : 1'b0;
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic set_fn(int f, int a, int b, int c);
      mod_a[f*W +: W] = W'(a); mod_b[f*W +: W] = W'(b); mod_c[f*W +: W] = W'(c);
   endtask

   task automatic run_chain(bit gaps);
      capture = 1; step(); capture = 0;
      if (!gaps) begin
         shift_en = 1; repeat (LEN) step(); shift_en = 0;
      end else begin
         for (int i = 0; i < 2 * LEN; i++) begin shift_en = i[0] ? 1'b0 : 1'b1; step(); end
         shift_en = 0;
      end
      step();
   endtask

   initial begin
      repeat (3) step();
      chk(scan_out == 0, "R3", scan_out, 0);
      chk(scan_done == 0, "R5", scan_done, 0);
      chk(result_valid == 0 && result_code == 0, "R6", result_code, 0);
      rst_n = 1; step();

      // all copies agree
      set_fn(0, 4'h5, 4'h5, 4'h5); set_fn(1, 4'hA, 4'hA, 4'hA); run_chain(0);
      chk(result_code == 6'o00, "R7", result_code, 6'o00);
      // single copy faults
      set_fn(0, 4'h3, 4'h7, 4'h3); set_fn(1, 4'h9, 4'h9, 4'h1); run_chain(1);
      chk(result_code == {3'd3, 3'd2}, "R8", result_code, {3'd3, 3'd2});
      set_fn(0, 4'hE, 4'h6, 4'h6); set_fn(1, 4'h0, 4'h0, 4'h0); run_chain(0);
      chk(result_code == {3'd0, 3'd1}, "R8", result_code, {3'd0, 3'd1});
      // all three differ
      set_fn(0, 4'h1, 4'h2, 4'h4); set_fn(1, 4'hF, 4'hF, 4'hF); run_chain(0);
      chk(result_code == {3'd0, 3'd5}, "R10", result_code, {3'd0, 3'd5});
      // return-path corruption: voted bit of fn1, flag of fn0
      set_fn(0, 4'h8, 4'h8, 4'h8); set_fn(1, 4'h6, 4'h6, 4'h6);
      inj = '0; inj[SEG + 3*W] = 1; inj[SEG - 1] = 1; run_chain(0);
      chk(result_code == {3'd4, 3'd4}, "R9", result_code, {3'd4, 3'd4});
      // neighbouring copy bits disturbed in fn1
      inj = '0; inj[SEG] = 1; inj[SEG + W + 1] = 1; run_chain(0);
      chk(result_code[5:3] == 3'd5, "R10", result_code[5:3], 5);
      inj = '0;
      // shifting past the end
      capture = 1; step(); capture = 0; shift_en = 1;
      repeat (LEN + 6) step(); shift_en = 0;
      chk(scan_out == 0 && scan_done == 0, "R5", {scan_out, scan_done}, 0);
      // restart mid-stream
      capture = 1; step(); capture = 0; shift_en = 1; repeat (10) step();
      set_fn(0, 4'h2, 4'h2, 4'hB);
      capture = 1; step(); capture = 0;
      chk(result_valid == 0, "R11", result_valid, 0);
      for (int i = 1; i <= LEN; i++) begin
         step();
         chk(scan_done == (i == LEN), "R11", scan_done, i == LEN);
      end
      shift_en = 0; step();
      chk(result_code[2:0] == 3'd3, "R11", result_code[2:0], 3);
      // random mixtures
      for (int r = 0; r < 30; r++) begin
         for (int f = 0; f < NF; f++) begin
            int a = $urandom_range(15), s = $urandom_range(4);
            set_fn(f, a, (s == 2) ? $urandom_range(15) : a,
                   (s == 3) ? $urandom_range(15) : ((s == 4) ? $urandom_range(15) : a));
            if (s == 1) mod_a[f*W +: W] = W'($urandom_range(15));
         end
         inj = (r % 4 == 0) ? (LEN'(1) << $urandom_range(LEN - 1)) : '0;
         run_chain(r[0]);
      end
      inj = '0;
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule